// File: doc/BRIEF.md
# DMA Channel Request and Completion Controller

This block owns the request side of a single DMA channel. It chooses one peripheral interrupt line through a 6-bit source select. It remembers at most one outstanding request in a pending flag, and it launches a transfer cycle to an external bus engine when the channel is enabled. The bus engine reports the end of each cycle with a one-cycle done pulse. The block counts these pulses against a programmed transfer count and, when the count runs out, disables the channel and raises a terminal-count flag.

Software sees the channel through four 16-bit registers. Offset 0 is control: bit 0 enable, bit 1 initialize strobe, bit 2 software start strobe, bit 7 terminal count, and bits 6..3 reserved. Offset 1 is trigger: bits 5..0 source select and bit 7 pending. Offset 2 is the transfer-count reload value. Offset 3 is the live count, which is read-only. Reads are combinational on the address. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `dma_chan_trigctl`

## Requirements
- R1: After reset, control reads 0, trigger reads 0, the count reads 0, and `xfer_start` and `xfer_busy` are low.
- R2: With select value k in 1..NUM_IRQ, a pulse on `irq_lines[k-1]` sets the pending flag (trigger bit 7) on the next edge, whether or not the channel is enabled. Lines that are not selected, select 0 and select values above NUM_IRQ set nothing.
- R3: While enable and pending are both 1 and no cycle is active, `xfer_start` is high. On the next edge pending clears and `xfer_busy` rises.
- R4: A request that arrives while pending is already 1 or while a cycle is active is discarded. It is not remembered afterwards.
- R5: While `standby` is high, the interrupt lines do not set the pending flag.
- R6: A done pulse that arrives with the live count at 0 clears enable on the next edge, leaving TC=0 and EN=0 for one cycle. TC becomes 1 on the edge after that, and the count reloads.
- R7: A done pulse during an active cycle with a nonzero count decrements the count by one. A done pulse with no active cycle has no effect.
- R8: Control bits 1 and 2 always read 0, bits 6..3 always read 0, and writing bit 7 does not change TC.
- R9: Writing trigger bit 7 as 0 clears the pending flag. Writing it as 1 leaves the flag unchanged.
- R10: A software start and a hardware trigger in the same cycle produce exactly one request and one transfer cycle.
- R11: The initialize strobe clears enable, pending, TC and any active cycle, and reloads the count from the reload register.
- R12: Writing control with bit 0 set clears TC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_IRQ | Peripheral interrupt pulses |
| standby | input | 1 | Standby indicator; masks interrupt requests |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| xfer_done | input | 1 | End-of-cycle pulse from the bus engine |
| xfer_start | output | 1 | Launch of a transfer cycle |
| xfer_busy | output | 1 | A transfer cycle is in progress |

## Verification
A software start strobe and a hardware interrupt on the selected line can land on the same clock edge. The bench drives the control write and the interrupt pulse together on an enabled, idle channel. It then requires that `xfer_start` rises for exactly one cycle, that pending is clear once the cycle is running, and that a single done pulse lowers the count by exactly one. The bench also exercises a related collision, a request arriving while a cycle is already in flight, and requires that it leaves no trace.

// File: rtl/dmatc_pkg.sv
package dmatc_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 6;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_TRIG   = 2'd1;
  localparam logic [1:0] A_RELOAD = 2'd2;
  localparam logic [1:0] A_COUNT  = 2'd3;

  localparam int B_EN   = 0;
  localparam int B_INIT = 1;
  localparam int B_SW   = 2;
  localparam int B_TC   = 7;
  localparam int B_PEND = 7;

  // Control readback: strobes and reserved bits always zero.
  function automatic logic [DATA_W-1:0] pack_ctrl(input logic en, input logic tc);
    logic [DATA_W-1:0] v;
    v = '0;
    v[B_EN] = en;
    v[B_TC] = tc;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pack_trig(input logic pend, input logic [SEL_W-1:0] sel);
    logic [DATA_W-1:0] v;
    v = '0;
    v[SEL_W-1:0] = sel;
    v[B_PEND] = pend;
    return v;
  endfunction
endpackage

// File: rtl/dmatc_trig_sel.sv
module dmatc_trig_sel #(
  parameter int NUM_IRQ = 16,
  parameter int SEL_W   = 6
) (
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [SEL_W-1:0]   sel,
  input  logic               standby,
  output logic               hw_evt
);
  logic [NUM_IRQ-1:0] match;

  // Select value 0 names no source; value i+1 picks line i.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign match[i] = irq_lines[i] && (sel == SEL_W'(i + 1));
  end

  assign hw_evt = (|match) && !standby;
endmodule

// File: rtl/dmatc_req_latch.sv
module dmatc_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic req,
  input  logic launch,
  input  logic cancel,
  input  logic busy,
  output logic pend_q,
  output logic accept
);
  // One slot only: requests during pending or busy are dropped.
  assign accept = req && !pend_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pend_q <= 1'b0;
    else if (init || launch)  pend_q <= 1'b0;
    else if (accept)          pend_q <= 1'b1;
    else if (cancel)          pend_q <= 1'b0;
  end
endmodule

// File: rtl/dmatc_xfer_cnt.sv
module dmatc_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             done_ok,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             term_evt
);
  function automatic logic is_last(input logic [CNT_W-1:0] cur);
    return cur == '0;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] rel);
    return is_last(cur) ? rel : cur - CNT_W'(1);
  endfunction

  assign term_evt = done_ok && is_last(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
    end else if (load_wr) begin
      reload_q <= load_val;
      count_q  <= load_val;
    end else if (init) begin
      count_q  <= reload_q;
    end else if (done_ok) begin
      count_q  <= cnt_next(count_q, reload_q);
    end
  end
endmodule

// File: rtl/dmatc_chan_state.sv
module dmatc_chan_state (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic ctrl_wr,
  input  logic en_bit,
  input  logic term_evt,
  input  logic launch,
  input  logic done_ok,
  output logic en_q,
  output logic tc_q,
  output logic tc_arm_q,
  output logic act_q
);
  // Terminal count takes priority over a same-cycle enable write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (init)     en_q <= 1'b0;
    else if (term_evt) en_q <= 1'b0;
    else if (ctrl_wr)  en_q <= en_bit;
  end

  // TC is set one edge after enable drops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_arm_q <= 1'b0;
    else        tc_arm_q <= term_evt && !init;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tc_q <= 1'b0;
    else if (init)                tc_q <= 1'b0;
    else if (ctrl_wr && en_bit)   tc_q <= 1'b0;
    else if (tc_arm_q)            tc_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= 1'b0;
    else if (init)    act_q <= 1'b0;
    else if (launch)  act_q <= 1'b1;
    else if (done_ok) act_q <= 1'b0;
  end
endmodule

// File: rtl/dma_chan_trigctl.sv
module dma_chan_trigctl #(
  parameter int NUM_IRQ = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               standby,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               xfer_done,
  output logic               xfer_start,
  output logic               xfer_busy
);
  import dmatc_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic wr_ctrl, wr_trig, wr_reload;
  logic init, sw_evt, hw_evt, en1_wr, cancel;
  logic launch, done_ok, term_evt, accept;
  logic en_q, tc_q, tc_arm_q, act_q, pend_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] count_q, reload_q;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_trig   = reg_wr && (reg_addr == A_TRIG);
  assign wr_reload = reg_wr && (reg_addr == A_RELOAD);

  assign init    = wr_ctrl && reg_wdata[B_INIT];
  assign sw_evt  = wr_ctrl && reg_wdata[B_SW] && !init;
  assign en1_wr  = wr_ctrl && reg_wdata[B_EN] && !init;
  assign cancel  = wr_trig && !reg_wdata[B_PEND];
  assign done_ok = xfer_done && act_q;
  assign launch  = pend_q && en_q && !act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (wr_trig) sel_q <= reg_wdata[SEL_W-1:0];
  end

  dmatc_trig_sel #(.NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)) u_sel (
    .irq_lines(irq_lines), .sel(sel_q), .standby(standby), .hw_evt(hw_evt)
  );

  dmatc_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .init(init), .req(hw_evt || sw_evt),
    .launch(launch), .cancel(cancel), .busy(act_q),
    .pend_q(pend_q), .accept(accept)
  );

  dmatc_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .init(init), .load_wr(wr_reload),
    .load_val(reg_wdata[CNT_W-1:0]), .done_ok(done_ok),
    .count_q(count_q), .reload_q(reload_q), .term_evt(term_evt)
  );

  dmatc_chan_state u_state (
    .clk(clk), .rst_n(rst_n), .init(init), .ctrl_wr(wr_ctrl && !init),
    .en_bit(reg_wdata[B_EN]), .term_evt(term_evt), .launch(launch),
    .done_ok(done_ok), .en_q(en_q), .tc_q(tc_q), .tc_arm_q(tc_arm_q),
    .act_q(act_q)
  );

  assign xfer_start = launch;
  assign xfer_busy  = act_q;

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = pack_ctrl(en_q, tc_q);
      A_TRIG:   reg_rdata = pack_trig(pend_q, sel_q);
      A_RELOAD: reg_rdata = DATA_W'(reload_q);
      default:  reg_rdata = DATA_W'(count_q);
    endcase
  end
endmodule

// File: rtl/dmatc_chk.sv
module dmatc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        init,
  input logic        sw_evt,
  input logic        en1_wr,
  input logic        term_evt,
  input logic        tc_arm_q,
  input logic        en_q,
  input logic        tc_q,
  input logic        pend_q,
  input logic        standby,
  input logic        xfer_start,
  input logic        xfer_busy,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_rdata
);
  assert_start_then_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && !init |=> xfer_busy && !xfer_start && !pend_q);

  assert_busy_drops_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |=> !pend_q);

  assert_standby_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    standby && !sw_evt && !pend_q |=> !pend_q);

  assert_term_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt && !init |=> !en_q && !tc_q);

  assert_tc_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_arm_q && !init && !en1_wr |=> tc_q);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd0 |-> reg_rdata[6:1] == 6'd0);

  assert_init_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !en_q && !pend_q && !tc_q && !xfer_busy);
endmodule

bind dma_chan_trigctl dmatc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .sw_evt(sw_evt), .en1_wr(en1_wr),
  .term_evt(term_evt), .tc_arm_q(tc_arm_q), .en_q(en_q), .tc_q(tc_q),
  .pend_q(pend_q), .standby(standby), .xfer_start(xfer_start),
  .xfer_busy(xfer_busy), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/dma_chan_trigctl_tb.sv
`timescale 1ns/1ps
module dma_chan_trigctl_tb;
  localparam int NI = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_lines = '0;
  logic          standby = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          xfer_done = 1'b0;
  logic          xfer_start, xfer_busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_chan_trigctl #(.NUM_IRQ(NI), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .standby(standby),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xfer_done(xfer_done), .xfer_start(xfer_start),
    .xfer_busy(xfer_busy)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic pulse_irq(input int ln);
    irq_lines = NI'(1) << ln;
    tick();
    irq_lines = '0;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 trig", v, 0);
    rd(2'd3, v); check("R1 count", v, 0);
    check("R1 start", xfer_start, 0);
    check("R1 busy", xfer_busy, 0);

    // R2 sweep of select values against every line, channel disabled
    for (int s = 0; s <= NI + 1; s++) begin
      for (int ln = 0; ln < NI; ln++) begin
        wr(2'd1, 16'(s));
        pulse_irq(ln);
        rd(2'd1, v);
        check("R2 pend", v[7], (s == ln + 1) ? 1 : 0);
      end
      // R5 standby masks the matching line
      if (s >= 1 && s <= NI) begin
        wr(2'd1, 16'(s));
        standby = 1'b1;
        pulse_irq(s - 1);
        standby = 1'b0;
        rd(2'd1, v); check("R5 standby", v[7], 0);
      end
    end

    // R9 pending write semantics
    wr(2'd1, 16'd3);
    pulse_irq(2);
    wr(2'd1, 16'h0083);
    rd(2'd1, v); check("R9 write1 keeps", v, 16'h0083);
    wr(2'd1, 16'h0003);
    rd(2'd1, v); check("R9 write0 clears", v, 16'h0003);

    // R8 readback format
    wr(2'd0, 16'h00F8);
    rd(2'd0, v); check("R8 tc/rsvd", v, 0);
    wr(2'd0, 16'h0004);
    rd(2'd0, v); check("R8 sw reads 0", v, 0);
    wr(2'd0, 16'h0002);
    rd(2'd0, v); check("R8 init reads 0", v, 0);
    wr(2'd1, 16'h0000);

    // R6 R7 R12 sweep over small counts
    for (int r = 0; r < 4; r++) begin
      wr(2'd2, 16'(r));
      wr(2'd0, 16'h0002);
      rd(2'd3, v); check("R11 reload", v, r);
      wr(2'd0, 16'h0001);
      for (int k = 0; k <= r; k++) begin
        wr(2'd0, 16'h0005);
        check("R3 start", xfer_start, 1);
        tick();
        check("R3 busy", xfer_busy, 1);
        check("R3 one pulse", xfer_start, 0);
        pulse_done();
        if (k < r) begin
          rd(2'd3, v); check("R7 dec", v, r - k - 1);
          rd(2'd0, v); check("R7 still en", v, 1);
        end else begin
          rd(2'd0, v); check("R6 gap EN0 TC0", v, 0);
          rd(2'd3, v); check("R6 reload", v, r);
          tick();
          rd(2'd0, v); check("R6 TC set", v, 16'h0080);
          wr(2'd0, 16'h0001);
          rd(2'd0, v); check("R12 en clears tc", v, 1);
        end
      end
    end

    // R7 stray done pulse while idle
    wr(2'd2, 16'd7);
    pulse_done();
    rd(2'd3, v); check("R7 idle done", v, 7);

    // R4 drop while pending and while busy
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'd2);
    pulse_irq(1);
    rd(2'd1, v); check("R2 pend disabled", v[7], 1);
    pulse_irq(1);
    wr(2'd0, 16'h0001);
    check("R3 enable starts", xfer_start, 1);
    tick();
    check("R4 busy", xfer_busy, 1);
    pulse_irq(1);
    wr(2'd0, 16'h0005);
    rd(2'd1, v); check("R4 dropped busy", v[7], 0);
    pulse_done();
    check("R4 no restart", xfer_start, 0);
    check("R4 idle", xfer_busy, 0);
    rd(2'd3, v); check("R4 one xfer", v, 4);
    tick();
    check("R4 none queued", xfer_start, 0);

    // R10 software and hardware in the same cycle
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0005; irq_lines = NI'(2);
    tick();
    reg_wr = 1'b0; irq_lines = '0;
    check("R10 start", xfer_start, 1);
    tick();
    check("R10 single", xfer_start, 0);
    rd(2'd1, v); check("R10 no second pend", v[7], 0);
    pulse_done();
    check("R10 no second start", xfer_start, 0);
    rd(2'd3, v); check("R10 count", v, 3);

    // R11 initialize during a cycle
    wr(2'd0, 16'h0005);
    tick();
    check("R11 busy before", xfer_busy, 1);
    wr(2'd0, 16'h0002);
    check("R11 busy cleared", xfer_busy, 0);
    rd(2'd0, v); check("R11 ctrl", v, 0);
    rd(2'd1, v); check("R11 pend", v[7], 0);
    rd(2'd3, v); check("R11 count", v, 5);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule